// File: doc/BRIEF.md
# Serial Flash Power-Up Instruction Gate

This block sits between the instruction decoder of a serial flash memory and its core. It decides, instruction by instruction, whether a decoded command may proceed while the supply ramps up or collapses. Two digital supply-monitor flags drive it. The first says the supply is above the write-lockout threshold. The second says it is above the minimum operating level. Each flag starts its own cycle-count delay timer.

Commands that alter the array or its write latch open only when both timers have expired. Reads and every other opcode need only the select timer. While the lockout flag is low, or while the external active-low reset is asserted, the whole block is held in reset and ignores every command. On leaving reset the status starts as standby (not deep power-down), with the write-enable latch clear and the busy bit clear.

Each command strobe produces exactly one registered pulse in the following cycle, either accept or reject.

Top module: `flash_pwr_gate`

## Requirements
- R1: While `lockout_ok` is low, `core_rst_n` is low, no accept or reject pulse is produced for any command, and every status output reads 0. When the flag falls during operation, the timers and status clear at once.
- R2: While `rst_ext_n` is low, the block behaves exactly as in R1, whatever the state of the supply flags.
- R3: The write class consists of opcodes 0x06 (write enable), 0x0A (page write), 0x02 (page program), 0xDB (page erase) and 0xD8 (sector erase). A write-class command is rejected unless, before its sampling edge, the lockout timer has counted `WLOCK_CYCLES` rising edges since the block last left reset.
- R4: A write-class command is accepted only if both timers have expired: the lockout timer (R3) and the select timer (`SEL_CYCLES` rising edges with `vmin_ok` high since it last rose). Otherwise it is rejected.
- R5: Opcode 0x03 (read) and every opcode outside the write class are accepted once the select timer has expired, whatever the state of the lockout timer. Before that they are rejected.
- R6: A command with `cmd_valid` high at a rising edge yields exactly one one-cycle pulse after that edge, on either `cmd_accept` or `cmd_reject`. With `cmd_valid` low, neither output pulses.
- R7: On leaving reset, `status_deep_pd` is 0 (standby), `status_wr_en` is 0 and `status_busy` is 0.
- R8: An accepted 0x06 sets `status_wr_en` after its sampling edge. A rejected command leaves every status output unchanged.
- R9: A low `vmin_ok` clears the select timer. Counting restarts from zero when the flag returns high, and reads are rejected again until the timer expires anew.
- R10: A drop of `lockout_ok` part-way through counting restarts both timers from zero. No write-class command is accepted before the full delays have run again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ext_n | input | 1 | External reset, active low |
| lockout_ok | input | 1 | Supply above write-lockout threshold |
| vmin_ok | input | 1 | Supply above minimum operating level |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_opcode | input | 8 | Decoded opcode |
| cmd_accept | output | 1 | One-cycle accept pulse |
| cmd_reject | output | 1 | One-cycle reject pulse |
| core_rst_n | output | 1 | Internal reset to the core, active low |
| status_wr_en | output | 1 | Write-enable latch status |
| status_busy | output | 1 | Write-in-progress status |
| status_deep_pd | output | 1 | Power mode: 1 = deep power-down, 0 = standby |

## Verification
The assertions assume that both supply flags, the external reset and the command inputs are already synchronous to `clk`. They also assume these inputs change only between rising edges, and that `cmd_opcode` holds steady while `cmd_valid` is high. The bench drives every input just after the falling edge. Its random flag drops, including those that land mid-count, are therefore always whole-cycle events that a clocked property can see. The bench's reference model counts edges the same way the requirements do.

// File: rtl/flash_pwr_gate_pkg.sv
package flash_pwr_gate_pkg;

    localparam int unsigned OP_W = 8;

    localparam logic [OP_W-1:0] OP_WREN = 8'h06;
    localparam logic [OP_W-1:0] OP_PW   = 8'h0A;
    localparam logic [OP_W-1:0] OP_PP   = 8'h02;
    localparam logic [OP_W-1:0] OP_PE   = 8'hDB;
    localparam logic [OP_W-1:0] OP_SE   = 8'hD8;
    localparam logic [OP_W-1:0] OP_READ = 8'h03;

    // Gating class of a decoded opcode
    typedef enum logic [1:0] {
        CLS_READ   = 2'd0,
        CLS_WREN   = 2'd1,
        CLS_MODIFY = 2'd2
    } op_class_e;

    // Registered state of the gate; all-zero is the reset value
    typedef struct packed {
        logic accept;
        logic reject;
        logic wr_en;
        logic busy;
        logic deep_pd;
    } gate_state_t;

endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
    parameter int unsigned DELAY = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(DELAY + 2);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LIMIT);

    generate
        if (DELAY > 0) begin : g_restart_chk
            // R9
            restart_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
                !run |=> !expired);
        end
    endgenerate

    // R10
    expiry_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (expired && run) |=> expired);

endmodule

// File: rtl/flash_op_classifier.sv
module flash_op_classifier
    import flash_pwr_gate_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_class_e       op_class
);
    always_comb begin
        case (opcode)
            OP_WREN:                    op_class = CLS_WREN;
            OP_PW, OP_PP, OP_PE, OP_SE: op_class = CLS_MODIFY;
            default:                    op_class = CLS_READ;
        endcase
    end
endmodule

// File: rtl/flash_pwr_gate.sv
module flash_pwr_gate
    import flash_pwr_gate_pkg::*;
#(
    parameter int unsigned WLOCK_CYCLES = 40,
    parameter int unsigned SEL_CYCLES   = 25
) (
    input  logic            clk,
    input  logic            rst_ext_n,
    input  logic            lockout_ok,
    input  logic            vmin_ok,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_opcode,
    output logic            cmd_accept,
    output logic            cmd_reject,
    output logic            core_rst_n,
    output logic            status_wr_en,
    output logic            status_busy,
    output logic            status_deep_pd
);
    localparam int unsigned N_TMR   = 2;
    localparam int unsigned IDX_WLK = 0;
    localparam int unsigned IDX_SEL = 1;

    logic             gate_rst_n;
    logic [N_TMR-1:0] tmr_run;
    logic [N_TMR-1:0] tmr_done;
    op_class_e        op_cls;
    logic             wr_open, rd_open, allow;
    gate_state_t      st_d, st_q;

    // Supply below lockout or external reset holds everything in reset
    assign gate_rst_n = lockout_ok & rst_ext_n;
    assign core_rst_n = gate_rst_n;

    assign tmr_run[IDX_WLK] = lockout_ok;
    assign tmr_run[IDX_SEL] = vmin_ok;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam int unsigned DLY = (g == IDX_WLK) ? WLOCK_CYCLES : SEL_CYCLES;
        pwr_delay_timer #(.DELAY(DLY)) u_tmr (
            .clk     (clk),
            .arst_n  (gate_rst_n),
            .run     (tmr_run[g]),
            .expired (tmr_done[g])
        );
    end

    flash_op_classifier u_cls (
        .opcode   (cmd_opcode),
        .op_class (op_cls)
    );

    assign rd_open = tmr_done[IDX_SEL];
    assign wr_open = tmr_done[IDX_SEL] & tmr_done[IDX_WLK];
    assign allow   = (op_cls == CLS_READ) ? rd_open : wr_open;

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.reject = 1'b0;
        if (cmd_valid) begin
            if (allow) begin
                st_d.accept = 1'b1;
                if (op_cls == CLS_WREN) begin
                    st_d.wr_en = 1'b1;
                end
            end else begin
                st_d.reject = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge gate_rst_n) begin
        if (!gate_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_accept     = st_q.accept;
    assign cmd_reject     = st_q.reject;
    assign status_wr_en   = st_q.wr_en;
    assign status_busy    = st_q.busy;
    assign status_deep_pd = st_q.deep_pd;

    // R6
    one_pulse_chk: assert property (@(posedge clk) disable iff (!gate_rst_n)
        cmd_valid |=> (cmd_accept != cmd_reject));

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!gate_rst_n)
        !cmd_valid |=> !(cmd_accept || cmd_reject));

    // R4
    write_gate_chk: assert property (@(posedge clk) disable iff (!gate_rst_n)
        (cmd_valid && op_cls != CLS_READ && !(tmr_done[IDX_WLK] && tmr_done[IDX_SEL]))
        |=> cmd_reject);

    // R5
    read_open_chk: assert property (@(posedge clk) disable iff (!gate_rst_n)
        (cmd_valid && op_cls == CLS_READ && tmr_done[IDX_SEL]) |=> cmd_accept);

    // R8
    wel_source_chk: assert property (@(posedge clk) disable iff (!gate_rst_n)
        $rose(status_wr_en) |-> $past(cmd_valid && cmd_opcode == OP_WREN));

    // R8
    reject_keeps_status_chk: assert property (@(posedge clk) disable iff (!gate_rst_n)
        cmd_reject |-> $stable(status_wr_en));

endmodule

// File: tb/flash_pwr_gate_test.sv
module flash_pwr_gate_test;
    localparam int unsigned WL  = 20;
    localparam int unsigned SEL = 12;

    logic       clk = 1'b0;
    logic       rst_ext_n = 1'b1;
    logic       lockout_ok = 1'b1;
    logic       vmin_ok = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_opcode = 8'h00;
    logic       cmd_accept, cmd_reject, core_rst_n;
    logic       status_wr_en, status_busy, status_deep_pd;

    always #5 clk = ~clk;

    flash_pwr_gate #(.WLOCK_CYCLES(WL), .SEL_CYCLES(SEL)) uut (
        .clk            (clk),
        .rst_ext_n      (rst_ext_n),
        .lockout_ok     (lockout_ok),
        .vmin_ok        (vmin_ok),
        .cmd_valid      (cmd_valid),
        .cmd_opcode     (cmd_opcode),
        .cmd_accept     (cmd_accept),
        .cmd_reject     (cmd_reject),
        .core_rst_n     (core_rst_n),
        .status_wr_en   (status_wr_en),
        .status_busy    (status_busy),
        .status_deep_pd (status_deep_pd)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    chk_on = 1'b0;

    int m_wl = 0, m_sel = 0;
    bit m_acc = 0, m_rej = 0, m_wel = 0, m_ok = 0;

    function automatic bit is_write_op(input logic [7:0] op);
        return (op == 8'h06) || (op == 8'h0A) || (op == 8'h02) ||
               (op == 8'hDB) || (op == 8'hD8);
    endfunction

    task automatic cmp(input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model, evaluated at each rising edge from stable inputs
    always @(posedge clk) begin
        if (!(lockout_ok && rst_ext_n)) begin
            m_wl = 0; m_sel = 0; m_acc = 0; m_rej = 0; m_wel = 0;
        end else begin
            m_ok  = is_write_op(cmd_opcode) ? (m_wl >= WL && m_sel >= SEL) : (m_sel >= SEL);
            m_acc = cmd_valid && m_ok;
            m_rej = cmd_valid && !m_ok;
            if (m_acc && cmd_opcode == 8'h06) m_wel = 1;
            if (m_wl < WL) m_wl++;
            if (!vmin_ok) m_sel = 0;
            else if (m_sel < SEL) m_sel++;
        end
        if (chk_on) begin
            #2;
            cmp("accept", cmd_accept, m_acc);
            cmp("reject", cmd_reject, m_rej);
            cmp("wel", status_wr_en, m_wel);
            cmp("busy", status_busy, 1'b0);
            cmp("deep_pd", status_deep_pd, 1'b0);
            cmp("core_rst_n", core_rst_n, lockout_ok && rst_ext_n);
        end
    end

    task automatic cmds(input int n, input logic [7:0] op_a, input logic [7:0] op_b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid  = 1'b1;
            cmd_opcode = (i % 2 == 0) ? op_a : op_b;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic supply(input logic lk, input logic vm, input int n);
        @(negedge clk);
        lockout_ok = lk;
        vmin_ok    = vm;
        repeat (n) @(negedge clk);
    endtask

    logic [7:0] op_pool [8];

    initial begin
        void'($urandom(32'h1A2B3C4D));
        op_pool[0] = 8'h06; op_pool[1] = 8'h0A; op_pool[2] = 8'h02; op_pool[3] = 8'hDB;
        op_pool[4] = 8'hD8; op_pool[5] = 8'h03; op_pool[6] = 8'h9F; op_pool[7] = 8'h05;
        #1;
        lockout_ok = 1'b0;
        rst_ext_n  = 1'b1;
        @(posedge clk);
        chk_on = 1'b1;

        // R1: lockout flag low, commands ignored
        tag = "R1";
        vmin_ok = 1'b1;
        cmds(6, 8'h06, 8'h03);

        // R4: lockout delay runs out while the select timer is held
        tag = "R4";
        supply(1'b1, 1'b0, 0);
        cmds(WL + 4, 8'h06, 8'h02);

        // R5: select timer runs, reads open while the write path already has its delay
        tag = "R5";
        supply(1'b1, 1'b1, 0);
        cmds(SEL + 3, 8'h03, 8'h9F);

        // R8: write enable now accepted, latch set
        tag = "R8";
        cmds(2, 8'h06, 8'h03);

        // R7: fresh reset, status back to standby and clear
        tag = "R7";
        supply(1'b0, 1'b1, 3);

        // R3: both flags rise together; reads open at SEL, writes only at WL
        tag = "R3";
        supply(1'b1, 1'b1, 0);
        cmds(WL + 6, 8'h02, 8'h03);

        // R10: lockout drop mid-count restarts both timers
        tag = "R10";
        supply(1'b0, 1'b1, 2);
        supply(1'b1, 1'b1, 0);
        cmds(10, 8'hD8, 8'h06);
        supply(1'b0, 1'b1, 1);
        supply(1'b1, 1'b1, 0);
        cmds(WL + 5, 8'hD8, 8'h06);

        // R9: minimum-level drop closes reads again and restarts select timer
        tag = "R9";
        supply(1'b1, 1'b0, 3);
        cmds(4, 8'h03, 8'h0A);
        supply(1'b1, 1'b1, 0);
        cmds(SEL + 4, 8'h03, 8'h0A);

        // R2: external reset with good supply
        tag = "R2";
        @(negedge clk);
        rst_ext_n = 1'b0;
        cmds(6, 8'h06, 8'h03);
        @(negedge clk);
        rst_ext_n = 1'b1;

        // R6: constrained random traffic with occasional supply and reset events
        tag = "R6";
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            cmd_valid  = ($urandom % 2) == 0;
            cmd_opcode = op_pool[$urandom % 8];
            if (lockout_ok) begin
                if ($urandom % 180 == 0) lockout_ok = 1'b0;
            end else if ($urandom % 3 == 0) lockout_ok = 1'b1;
            if (vmin_ok) begin
                if ($urandom % 90 == 0) vmin_ok = 1'b0;
            end else if ($urandom % 4 == 0) vmin_ok = 1'b1;
            if (rst_ext_n) begin
                if ($urandom % 500 == 0) rst_ext_n = 1'b0;
            end else if ($urandom % 2 == 0) rst_ext_n = 1'b1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL %s watchdog: actual hung expected finished", tag);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule